// File: doc/BRIEF.md
# Colour Sensor Register Target on a Two-Wire Bus

This block is the serial programming front end of a four-channel (red, green, blue, clear) light sensor core. A bus controller addresses it over an I2C two-wire bus to set per-channel gain (capacitor count and integration time), to select the operating configuration, and to launch sensor or offset acquisitions. When the core finishes an acquisition it pulses a done strobe on its capture port, and the results become readable over the bus.

SCL and SDA are sampled on a fast system clock through a synchronizer. START, repeated START and STOP are recognised from those samples. The open-drain data line is represented by an output-enable that pulls the line low. One register is written per transaction: device address, register pointer, data byte. A read sets the pointer with a write, then issues a repeated START with the read bit and clocks the byte out.

Top module: `csens_i2c_target`

## Requirements
- R1: After the synchronous active-high reset, the four capacitor registers (0x06 red, 0x07 green, 0x08 blue, 0x09 clear) hold 0x0F and every other register holds zero. `cap_cfg` is therefore all ones, while `int_cfg`, the command outputs and the configuration outputs are all zero.
- R2: Only the 7-bit device address 0x74 is acknowledged. Bit 0 of the first byte selects the direction: 1 is read, 0 is write. For any other address the target leaves SDA released for the rest of that transaction and changes no register.
- R3: The write sequence is START, address with the write bit, pointer byte, data byte and STOP. Bytes are sent MSB first. The target pulls SDA low in the ninth clock of each of the three bytes.
- R4: In a read, a pointer write is followed by a repeated START and the address with the read bit. The target then shifts out the selected register MSB first, changing SDA only after SCL falls. A NACK from the controller ends the read.
- R5: In register 0x00, bit 0 requests a sensor reading and drives `cmd_sample`; bit 1 requests an offset reading and drives `cmd_offset`. Each bit is cleared on the cycle after its done pulse, and a done pulse wins over a write in the same cycle.
- R6: A `sample_done` pulse loads the four 10-bit results in the same cycle. Channel c is read as a low byte at 0x40+2c and as bits [9:8] of the byte at 0x41+2c. The channel order is red, green, blue, clear, and channel 0 sits in the least significant bits of `sample_data`.
- R7: An `offset_done` pulse loads four 8-bit offsets (sign in bit 7, magnitude in bits 6:0), read at 0x48+c in the same channel order.
- R8: Register 0x01 holds the trim enable in bit 0, sleep in bit 1 and external clock in bit 2. Sleep is stored as 1 only if bit 2 of the same written value is 1, so sleep never reads 1 while external clock is 0.
- R9: Capacitor registers hold 4 bits. Integration time is 12 bits per channel, with the low byte at 0x0A+2c and the high nibble at 0x0B+2c. All of these values appear on `cap_cfg` and `int_cfg`, and unused bits read as zero.
- R10: Writes to result, offset or unmapped addresses are acknowledged but change nothing. An unmapped address reads as 0x00.
- R11: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Resolved serial data line |
| sda_oe | output | 1 | 1 pulls SDA low |
| cmd_sample | output | 1 | Pending sensor-reading request |
| cmd_offset | output | 1 | Pending offset-reading request |
| cfg_trim | output | 1 | Trim-offset enable |
| cfg_sleep | output | 1 | Sleep request |
| cfg_extclk | output | 1 | External clock mode |
| cap_cfg | output | 16 | Capacitor setting, 4 bits per channel |
| int_cfg | output | 48 | Integration time, 12 bits per channel |
| sample_done | input | 1 | Core finished a sensor reading |
| sample_data | input | 40 | Four 10-bit results |
| offset_done | input | 1 | Core finished an offset reading |
| offset_data | input | 32 | Four 8-bit sign-magnitude offsets |

## Verification
Several properties are checked on every clock:
- the reset values on the configuration ports;
- command bits dropping right after their done pulse;
- sleep never being set without external clock;
- the SDA drive changing only during the SCL low phase.

Address matching, acknowledge placement, the register map, bit masking, the ignoring of read-only and unmapped writes, and the contents of captured results can only be shown by the bench. It runs complete bus transactions against a behavioural register model and compares read-back bytes and port values.

// File: rtl/csens_pkg.sv
package csens_pkg;
    localparam int NUM_CH_D = 4;
    localparam int CAP_W_D  = 4;
    localparam int INT_W_D  = 12;
    localparam int RES_W_D  = 10;
    localparam int OFS_W_D  = 8;

    localparam logic [6:0] DEV_ADDR = 7'h74;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_CFG  = 8'h01;
    localparam logic [7:0] A_CAP  = 8'h06;
    localparam logic [7:0] A_INT  = 8'h0A;
    localparam logic [7:0] A_RES  = 8'h40;
    localparam logic [7:0] A_OFS  = 8'h48;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_PTR,
        PH_WDAT,
        PH_RDAT
    } phase_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic start;
        logic stop;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [2:0] cfg_pack(input logic [7:0] d);
        return {d[2], d[1] & d[2], d[0]};
    endfunction
endpackage

// File: rtl/csens_bus_sync.sv
module csens_bus_sync
    import csens_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic                   scl_q, sda_q;
    logic                   scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_sh[SYNC_STAGES-1];
    assign sda_s = sda_sh[SYNC_STAGES-1];

    assign evt.rise  = scl_s & ~scl_q;
    assign evt.fall  = ~scl_s & scl_q;
    assign evt.start = scl_s & scl_q & sda_q & ~sda_s;
    assign evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    assign evt.sda   = sda_s;
endmodule

// File: rtl/csens_link.sv
module csens_link
    import csens_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_evt_t   evt,
    input  logic [7:0] rd_byte,
    output logic [7:0] ptr,
    output wr_req_t    wr,
    output logic       sda_oe
);
    localparam logic [3:0] BYTE_BITS = 4'd8;

    phase_t     phase;
    logic [3:0] cnt;
    logic       in_ack;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       hit;
    logic       rw_rd;
    logic       mnack;
    logic       match;

    assign match = (shreg[7:1] == DEV_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            in_ack <= 1'b0;
            shreg  <= '0;
            tx     <= '0;
            hit    <= 1'b0;
            rw_rd  <= 1'b0;
            mnack  <= 1'b1;
            ptr    <= '0;
            wr     <= '0;
            sda_oe <= 1'b0;
        end else begin
            wr.en <= 1'b0;
            if (evt.start) begin
                phase  <= PH_DEV;
                cnt    <= '0;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (evt.stop) begin
                phase  <= PH_IDLE;
                in_ack <= 1'b0;
                sda_oe <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (evt.rise) begin
                    if (in_ack) begin
                        mnack <= evt.sda;
                    end else if (cnt < BYTE_BITS) begin
                        shreg <= {shreg[6:0], evt.sda};
                        cnt   <= cnt + 4'd1;
                    end
                end else if (evt.fall) begin
                    if (!in_ack && cnt == BYTE_BITS) begin
                        in_ack <= 1'b1;
                        case (phase)
                            PH_DEV: begin
                                hit    <= match;
                                rw_rd  <= shreg[0];
                                sda_oe <= match;
                            end
                            PH_PTR: begin
                                ptr    <= shreg;
                                sda_oe <= 1'b1;
                            end
                            PH_WDAT: begin
                                wr     <= '{en: 1'b1, addr: ptr, data: shreg};
                                sda_oe <= 1'b1;
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (in_ack) begin
                        in_ack <= 1'b0;
                        cnt    <= '0;
                        case (phase)
                            PH_DEV: begin
                                if (!hit) begin
                                    phase  <= PH_IDLE;
                                    sda_oe <= 1'b0;
                                end else if (rw_rd) begin
                                    phase  <= PH_RDAT;
                                    tx     <= rd_byte;
                                    sda_oe <= ~rd_byte[7];
                                end else begin
                                    phase  <= PH_PTR;
                                    sda_oe <= 1'b0;
                                end
                            end
                            PH_PTR: begin
                                phase  <= PH_WDAT;
                                sda_oe <= 1'b0;
                            end
                            PH_RDAT: begin
                                if (mnack) begin
                                    phase  <= PH_IDLE;
                                    sda_oe <= 1'b0;
                                end else begin
                                    tx     <= rd_byte;
                                    sda_oe <= ~rd_byte[7];
                                end
                            end
                            default: sda_oe <= 1'b0;
                        endcase
                    end else if (phase == PH_RDAT && cnt != 4'd0) begin
                        tx     <= {tx[6:0], 1'b0};
                        sda_oe <= ~tx[6];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/csens_regs.sv
module csens_regs
    import csens_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_D,
    parameter int CAP_W  = CAP_W_D,
    parameter int INT_W  = INT_W_D,
    parameter int RES_W  = RES_W_D,
    parameter int OFS_W  = OFS_W_D
) (
    input  logic                     clk,
    input  logic                     rst,
    input  wr_req_t                  wr,
    input  logic [7:0]               rd_addr,
    output logic [7:0]               rd_byte,
    input  logic                     sample_done,
    input  logic [NUM_CH*RES_W-1:0]  sample_data,
    input  logic                     offset_done,
    input  logic [NUM_CH*OFS_W-1:0]  offset_data,
    output logic                     cmd_sample,
    output logic                     cmd_offset,
    output logic                     cfg_trim,
    output logic                     cfg_sleep,
    output logic                     cfg_extclk,
    output logic [NUM_CH*CAP_W-1:0]  cap_cfg,
    output logic [NUM_CH*INT_W-1:0]  int_cfg
);
    localparam int INT_HI_W = INT_W - 8;
    localparam int RES_HI_W = RES_W - 8;

    logic [1:0] ctrl_q, ctrl_n;
    logic [2:0] cfg_q;
    logic [NUM_CH-1:0][7:0] chan_rd;

    always_comb begin
        ctrl_n = ctrl_q;
        if (wr.en && wr.addr == A_CTRL) ctrl_n = wr.data[1:0];
        if (sample_done) ctrl_n[0] = 1'b0;
        if (offset_done) ctrl_n[1] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            if (wr.en && wr.addr == A_CFG) cfg_q <= cfg_pack(wr.data);
        end
    end

    assign cmd_sample = ctrl_q[0];
    assign cmd_offset = ctrl_q[1];
    assign cfg_trim   = cfg_q[0];
    assign cfg_sleep  = cfg_q[1];
    assign cfg_extclk = cfg_q[2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [7:0] CAP_A  = 8'(A_CAP + c);
        localparam logic [7:0] INT_LO = 8'(A_INT + 2 * c);
        localparam logic [7:0] INT_HI = 8'(A_INT + 2 * c + 1);
        localparam logic [7:0] RES_LO = 8'(A_RES + 2 * c);
        localparam logic [7:0] RES_HI = 8'(A_RES + 2 * c + 1);
        localparam logic [7:0] OFS_A  = 8'(A_OFS + c);

        logic [CAP_W-1:0] cap_q;
        logic [INT_W-1:0] int_q;
        logic [RES_W-1:0] res_q;
        logic [OFS_W-1:0] ofs_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cap_q <= '1;
                int_q <= '0;
                res_q <= '0;
                ofs_q <= '0;
            end else begin
                if (wr.en && wr.addr == CAP_A)  cap_q <= wr.data[CAP_W-1:0];
                if (wr.en && wr.addr == INT_LO) int_q[7:0] <= wr.data;
                if (wr.en && wr.addr == INT_HI) int_q[INT_W-1:8] <= wr.data[INT_HI_W-1:0];
                if (sample_done) res_q <= sample_data[c*RES_W +: RES_W];
                if (offset_done) ofs_q <= offset_data[c*OFS_W +: OFS_W];
            end
        end

        assign cap_cfg[c*CAP_W +: CAP_W] = cap_q;
        assign int_cfg[c*INT_W +: INT_W] = int_q;

        assign chan_rd[c] = (rd_addr == CAP_A)  ? 8'(cap_q) :
                            (rd_addr == INT_LO) ? int_q[7:0] :
                            (rd_addr == INT_HI) ? 8'(int_q[INT_W-1:8]) :
                            (rd_addr == RES_LO) ? res_q[7:0] :
                            (rd_addr == RES_HI) ? 8'(res_q[RES_W-1:8]) :
                            (rd_addr == OFS_A)  ? 8'(ofs_q) : 8'h00;
    end

    always_comb begin
        rd_byte = 8'h00;
        if (rd_addr == A_CTRL) rd_byte = {6'b0, ctrl_q};
        if (rd_addr == A_CFG)  rd_byte = {5'b0, cfg_q};
        for (int c = 0; c < NUM_CH; c++) rd_byte = rd_byte | chan_rd[c];
    end

    logic unused_hi;
    assign unused_hi = (RES_HI_W > 0) ? 1'b0 : 1'b1;
endmodule

// File: rtl/csens_i2c_target.sv
module csens_i2c_target
    import csens_pkg::*;
#(
    parameter int NUM_CH      = NUM_CH_D,
    parameter int CAP_W       = CAP_W_D,
    parameter int INT_W       = INT_W_D,
    parameter int RES_W       = RES_W_D,
    parameter int OFS_W       = OFS_W_D,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_in,
    input  logic                    sda_in,
    output logic                    sda_oe,
    output logic                    cmd_sample,
    output logic                    cmd_offset,
    output logic                    cfg_trim,
    output logic                    cfg_sleep,
    output logic                    cfg_extclk,
    output logic [NUM_CH*CAP_W-1:0] cap_cfg,
    output logic [NUM_CH*INT_W-1:0] int_cfg,
    input  logic                    sample_done,
    input  logic [NUM_CH*RES_W-1:0] sample_data,
    input  logic                    offset_done,
    input  logic [NUM_CH*OFS_W-1:0] offset_data
);
    bus_evt_t   evt;
    wr_req_t    wr;
    logic [7:0] ptr;
    logic [7:0] rd_byte;

    csens_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    csens_link u_link (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_byte (rd_byte),
        .ptr     (ptr),
        .wr      (wr),
        .sda_oe  (sda_oe)
    );

    csens_regs #(
        .NUM_CH (NUM_CH),
        .CAP_W  (CAP_W),
        .INT_W  (INT_W),
        .RES_W  (RES_W),
        .OFS_W  (OFS_W)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_addr     (ptr),
        .rd_byte     (rd_byte),
        .sample_done (sample_done),
        .sample_data (sample_data),
        .offset_done (offset_done),
        .offset_data (offset_data),
        .cmd_sample  (cmd_sample),
        .cmd_offset  (cmd_offset),
        .cfg_trim    (cfg_trim),
        .cfg_sleep   (cfg_sleep),
        .cfg_extclk  (cfg_extclk),
        .cap_cfg     (cap_cfg),
        .int_cfg     (int_cfg)
    );
endmodule

// File: rtl/csens_checker.sv
module csens_checker #(
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_in,
    input logic             sda_oe,
    input logic             cmd_sample,
    input logic             cmd_offset,
    input logic             cfg_sleep,
    input logic             cfg_extclk,
    input logic [CFG_W-1:0] cap_cfg,
    input logic             sample_done,
    input logic             offset_done
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cap_cfg == '1 && !cmd_sample && !cmd_offset && !cfg_sleep && !sda_oe));

    assert_sample_clears_R5: assert property (@(posedge clk) disable iff (rst)
        sample_done |=> !cmd_sample);

    assert_offset_clears_R5: assert property (@(posedge clk) disable iff (rst)
        offset_done |=> !cmd_offset);

    assert_sleep_needs_extclk_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_sleep |-> cfg_extclk);

    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_in);
endmodule

bind csens_i2c_target csens_checker #(.CFG_W(NUM_CH*CAP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_in),
    .sda_oe      (sda_oe),
    .cmd_sample  (cmd_sample),
    .cmd_offset  (cmd_offset),
    .cfg_sleep   (cfg_sleep),
    .cfg_extclk  (cfg_extclk),
    .cap_cfg     (cap_cfg),
    .sample_done (sample_done),
    .offset_done (offset_done)
);

// File: tb/csens_i2c_target_bench.sv
module csens_i2c_target_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic cmd_sample, cmd_offset, cfg_trim, cfg_sleep, cfg_extclk;
    logic [15:0] cap_cfg;
    logic [47:0] int_cfg;
    logic sample_done = 1'b0;
    logic offset_done = 1'b0;
    logic [39:0] sample_data = '0;
    logic [31:0] offset_data = '0;

    int nchk = 0;
    int nfail = 0;

    logic [1:0]  m_ctrl = '0;
    logic [2:0]  m_cfg = '0;
    logic [3:0]  m_cap [4] = '{4'hF, 4'hF, 4'hF, 4'hF};
    logic [11:0] m_int [4] = '{default: '0};
    logic [9:0]  m_res [4] = '{default: '0};
    logic [7:0]  m_ofs [4] = '{default: '0};

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    csens_i2c_target u_csens_i2c_target (
        .clk (clk), .rst (rst), .scl_in (scl_m), .sda_in (sda_line), .sda_oe (sda_oe),
        .cmd_sample (cmd_sample), .cmd_offset (cmd_offset), .cfg_trim (cfg_trim),
        .cfg_sleep (cfg_sleep), .cfg_extclk (cfg_extclk), .cap_cfg (cap_cfg),
        .int_cfg (int_cfg), .sample_done (sample_done), .sample_data (sample_data),
        .offset_done (offset_done), .offset_data (offset_data)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h00) return {6'b0, m_ctrl};
        if (a == 8'h01) return {5'b0, m_cfg};
        if (a >= 8'h06 && a <= 8'h09) return {4'b0, m_cap[a-8'h06]};
        if (a >= 8'h0A && a <= 8'h11)
            return a[0] ? {4'b0, m_int[(a-8'h0A)>>1][11:8]} : m_int[(a-8'h0A)>>1][7:0];
        if (a >= 8'h40 && a <= 8'h47)
            return a[0] ? {6'b0, m_res[(a-8'h40)>>1][9:8]} : m_res[(a-8'h40)>>1][7:0];
        if (a >= 8'h48 && a <= 8'h4B) return m_ofs[a-8'h48];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h00) m_ctrl = d[1:0];
        else if (a == 8'h01) m_cfg = {d[2], d[1] & d[2], d[0]};
        else if (a >= 8'h06 && a <= 8'h09) m_cap[a-8'h06] = d[3:0];
        else if (a >= 8'h0A && a <= 8'h11) begin
            if (a[0]) m_int[(a-8'h0A)>>1][11:8] = d[3:0];
            else      m_int[(a-8'h0A)>>1][7:0]  = d;
        end
    endtask

    task automatic q();
        repeat (10) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0;
        end
        q(); sda_m = nack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        logic ack;
        bus_start();
        send_byte({7'h74, 1'b0}, ack); check("R3 address ack", ack, 1'b1);
        send_byte(a, ack);             check("R3 pointer ack", ack, 1'b1);
        send_byte(d, ack);             check("R3 data ack", ack, 1'b1);
        bus_stop();
        model_write(a, d);
    endtask

    task automatic reg_read(input string req, input logic [7:0] a);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte({7'h74, 1'b0}, ack);
        send_byte(a, ack);
        bus_start();
        send_byte({7'h74, 1'b1}, ack); check("R4 read address ack", ack, 1'b1);
        recv_byte(1'b1, b);
        bus_stop();
        check(req, b, model_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic ack;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        check("R1 cap_cfg reset", cap_cfg, 16'hFFFF);
        check("R1 int_cfg reset", int_cfg, 48'h0);
        check("R1 commands reset", {cmd_sample, cmd_offset, cfg_trim, cfg_sleep, cfg_extclk}, 5'b0);
        reg_read("R1 cap clear reads 0x0F", 8'h09);
        reg_read("R1 ctrl reads zero", 8'h00);

        reg_write(8'h0A, 8'h5C);
        reg_write(8'h0B, 8'hF3);
        reg_read("R9 int high nibble masked", 8'h0B);
        reg_read("R4 int low byte", 8'h0A);
        check("R9 int_cfg red", int_cfg[11:0], 12'h35C);
        reg_write(8'h08, 8'hA7);
        reg_read("R9 cap blue masked", 8'h08);
        check("R9 cap_cfg blue", cap_cfg[11:8], 4'h7);
        reg_write(8'h11, 8'h09);
        check("R9 int_cfg clear high", int_cfg[47:44], 4'h9);

        bus_start();
        send_byte({7'h75, 1'b0}, ack); check("R2 wrong address nack", ack, 1'b0);
        send_byte(8'h09, ack);         check("R2 no ack after mismatch", ack, 1'b0);
        send_byte(8'h00, ack);
        bus_stop();
        reg_read("R2 register untouched", 8'h09);

        reg_write(8'h01, 8'h03);
        reg_read("R8 sleep dropped without extclk", 8'h01);
        check("R8 sleep port low", {cfg_sleep, cfg_trim}, 2'b01);
        reg_write(8'h01, 8'h06);
        reg_read("R8 sleep kept with extclk", 8'h01);
        check("R8 ports", {cfg_extclk, cfg_sleep, cfg_trim}, 3'b110);

        reg_write(8'h00, 8'h01);
        check("R5 cmd_sample set", {cmd_offset, cmd_sample}, 2'b01);
        @(negedge clk);
        sample_data = {10'h07E, 10'h2C3, 10'h1F0, 10'h3A5};
        sample_done = 1'b1;
        @(negedge clk);
        sample_done = 1'b0;
        check("R5 cmd_sample cleared by done", cmd_sample, 1'b0);
        m_ctrl[0] = 1'b0;
        m_res[0] = 10'h3A5; m_res[1] = 10'h1F0; m_res[2] = 10'h2C3; m_res[3] = 10'h07E;
        for (int a = 8'h40; a <= 8'h47; a++) reg_read("R6 result byte", 8'(a));

        reg_write(8'h00, 8'h02);
        check("R5 cmd_offset set", {cmd_offset, cmd_sample}, 2'b10);
        @(negedge clk);
        offset_data = {8'h40, 8'hFF, 8'h12, 8'h85};
        offset_done = 1'b1;
        @(negedge clk);
        offset_done = 1'b0;
        check("R5 cmd_offset cleared by done", cmd_offset, 1'b0);
        m_ctrl[1] = 1'b0;
        m_ofs[0] = 8'h85; m_ofs[1] = 8'h12; m_ofs[2] = 8'hFF; m_ofs[3] = 8'h40;
        for (int a = 8'h48; a <= 8'h4B; a++) reg_read("R7 offset byte", 8'(a));

        reg_write(8'h41, 8'hAA);
        reg_read("R10 result write ignored", 8'h41);
        reg_write(8'h48, 8'h00);
        reg_read("R10 offset write ignored", 8'h48);
        reg_write(8'h20, 8'h55);
        reg_read("R10 unmapped reads zero", 8'h20);
        check("R10 outputs unchanged", {cap_cfg, int_cfg[11:0]}, {16'hF7FF, 12'h35C});

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule